// File: doc/BRIEF.md
# Link Bring-Up Speed Sequencer

This block drives the start of a serial link in two stages. After a start pulse it first withdraws the training enable. It then caps the allowed link speed at the first generation and turns training on. It waits for the link to report up. Once the link is up, it raises the speed cap to the second generation and issues a one-cycle request for a directed speed change. It then waits for the speed-change status bit to clear, and finally waits for the link to come up again. If every step succeeds, it latches the negotiated generation and reports done.

Each wait samples its condition only at poll instants. These come from a parameterised interval counter, so the poll spacing can be set to any number of clock cycles. Each wait has a budget of polls. When the budget runs out, the block stops and reports failure. The training logic, the PHY and the link partner all sit outside the block. The block only writes the control fields and reads back the status it needs.

Top module: `lnk_speed_seq`

## Requirements
- R1: Out of reset the speed cap reads 1, training enable, speed-change request, busy, done and fail are all 0, and the generation output reads 0.
- R2: A start pulse sampled at a clock edge makes training enable 0, busy 1, done 0 and fail 0 from that edge. The next edge sets the speed cap to 1, and the edge after that sets training enable to 1. Training is never enabled with a cap other than 1.
- R3: In each wait step the polled input is sampled only on the TICK_CYC-th cycle after entering the step, and then every TICK_CYC cycles. Values present between poll instants have no effect.
- R4: When a link-up poll succeeds in the first wait, the speed cap becomes 2 at that edge. The speed-change request is then high for exactly the following cycle.
- R5: The speed change counts as finished at the first poll that sees the speed-change status input at 0.
- R6: A wait step allows at most MAX_POLLS polls. If the last allowed poll also misses, fail goes to 1 and busy to 0 at that edge.
- R7: After the speed change finishes, a second link-up wait follows. When it succeeds, done goes to 1 and busy to 0, and the generation output takes the value of the 4-bit generation field input.
- R8: Done and fail hold until the next start pulse. A start pulse in any state, including mid-sequence, restarts the sequence from R2.
- R9: Busy is 1 from the edge after a start until the edge on which done or fail rises. Busy, done and fail are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start/restart pulse |
| link_up_i | input | 1 | Link reported up by training logic |
| spd_chg_busy_i | input | 1 | Read-back of the self-clearing speed-change bit |
| gen_field_i | input | 4 | Current-generation field of the link status word |
| max_spd_o | output | 4 | Speed cap field (1 = first gen, 2 = second gen) |
| train_en_o | output | 1 | Training enable |
| spd_chg_req_o | output | 1 | One-cycle write strobe that sets the speed-change bit |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence succeeded (sticky) |
| fail_o | output | 1 | A wait step ran out of polls (sticky) |
| gen_o | output | 4 | Generation latched on success |

## Verification
The bench builds the block with TICK_CYC = 4 and MAX_POLLS = 5, so a whole wait budget is only 20 cycles. This makes budget exhaustion in each of the three wait steps reachable in a short run. With these values, poll k of a wait step sees the partner's state after exactly 4·k cycles. That lets the bench place link-up exactly on the last allowed poll and one cycle after it. The bench also places glitches between poll instants, and a restart in the middle of the speed-change wait.

// File: rtl/lnk_speed_pkg.sv
package lnk_speed_pkg;

    localparam logic [3:0] SPD_CAP_G1 = 4'd1;
    localparam logic [3:0] SPD_CAP_G2 = 4'd2;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ARM      = 3'd1,
        ST_ENABLE   = 3'd2,
        ST_WAIT_UP1 = 3'd3,
        ST_RAISE    = 3'd4,
        ST_WAIT_CHG = 3'd5,
        ST_WAIT_UP2 = 3'd6
    } seq_st_e;

    typedef struct packed {
        seq_st_e    st;
        logic [3:0] max_spd;
        logic       train_en;
        logic       req;
        logic       busy;
        logic       done;
        logic       fail;
        logic [3:0] gen;
    } seq_regs_t;

endpackage

// File: rtl/lss_interval.sv
module lss_interval #(
    parameter int TICK_CYC = 25000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int TW = (TICK_CYC > 2) ? $clog2(TICK_CYC) : 1;
    localparam logic [TW-1:0] LAST = TW'(TICK_CYC - 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == LAST);
        if (!run_i || tick_o) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R3

endmodule

// File: rtl/lss_budget.sv
module lss_budget #(
    parameter int MAX_POLLS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int PW = (MAX_POLLS > 2) ? $clog2(MAX_POLLS) : 1;
    localparam logic [PW-1:0] LASTV = PW'(MAX_POLLS - 1);

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        last_o = (cnt_q == LASTV);
        if (clr_i)                 cnt_d = '0;
        else if (inc_i && !last_o) cnt_d = cnt_q + 1'b1;
        else                       cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_BUDGET_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LASTV); // R6

endmodule

// File: rtl/lnk_speed_seq.sv
module lnk_speed_seq
    import lnk_speed_pkg::*;
#(
    parameter int TICK_CYC  = 25000,
    parameter int MAX_POLLS = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       link_up_i,
    input  logic       spd_chg_busy_i,
    input  logic [3:0] gen_field_i,
    output logic [3:0] max_spd_o,
    output logic       train_en_o,
    output logic       spd_chg_req_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       fail_o,
    output logic [3:0] gen_o
);
    seq_regs_t r_d, r_q;

    logic in_wait, poll, cond, hit, miss, last, bud_clr, bud_inc;

    lss_interval #(.TICK_CYC(TICK_CYC)) u_tick (
        .clk(clk), .rst_n(rst_n), .run_i(in_wait), .tick_o(poll)
    );

    lss_budget #(.MAX_POLLS(MAX_POLLS)) u_budget (
        .clk(clk), .rst_n(rst_n), .clr_i(bud_clr), .inc_i(bud_inc), .last_o(last)
    );

    always_comb begin
        in_wait = (r_q.st == ST_WAIT_UP1) || (r_q.st == ST_WAIT_CHG) ||
                  (r_q.st == ST_WAIT_UP2);
        case (r_q.st)
            ST_WAIT_CHG: cond = !spd_chg_busy_i;
            default:     cond = link_up_i;
        endcase
        hit     = poll && cond;
        miss    = poll && !cond;
        bud_clr = !in_wait || hit || start_i;
        bud_inc = miss && !start_i;

        r_d     = r_q;
        r_d.req = 1'b0;
        if (start_i) begin
            r_d.st       = ST_ARM;
            r_d.train_en = 1'b0;
            r_d.busy     = 1'b1;
            r_d.done     = 1'b0;
            r_d.fail     = 1'b0;
            r_d.gen      = 4'd0;
        end else begin
            case (r_q.st)
                ST_ARM: begin
                    r_d.max_spd = SPD_CAP_G1;
                    r_d.st      = ST_ENABLE;
                end
                ST_ENABLE: begin
                    r_d.train_en = 1'b1;
                    r_d.st       = ST_WAIT_UP1;
                end
                ST_RAISE: begin
                    r_d.req = 1'b1;
                    r_d.st  = ST_WAIT_CHG;
                end
                ST_WAIT_UP1, ST_WAIT_CHG, ST_WAIT_UP2: begin
                    if (hit) begin
                        if (r_q.st == ST_WAIT_UP1) begin
                            r_d.max_spd = SPD_CAP_G2;
                            r_d.st      = ST_RAISE;
                        end else if (r_q.st == ST_WAIT_CHG) begin
                            r_d.st = ST_WAIT_UP2;
                        end else begin
                            r_d.done = 1'b1;
                            r_d.busy = 1'b0;
                            r_d.gen  = gen_field_i;
                            r_d.st   = ST_IDLE;
                        end
                    end else if (miss && last) begin
                        r_d.fail = 1'b1;
                        r_d.busy = 1'b0;
                        r_d.st   = ST_IDLE;
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.st      <= ST_IDLE;
            r_q.max_spd <= SPD_CAP_G1;
        end else begin
            r_q <= r_d;
        end
    end

    assign max_spd_o     = r_q.max_spd;
    assign train_en_o    = r_q.train_en;
    assign spd_chg_req_o = r_q.req;
    assign busy_o        = r_q.busy;
    assign done_o        = r_q.done;
    assign fail_o        = r_q.fail;
    assign gen_o         = r_q.gen;

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        spd_chg_req_o |=> !spd_chg_req_o); // R4
    AST_REQ_AT_GEN2: assert property (@(posedge clk) disable iff (!rst_n)
        spd_chg_req_o |-> (max_spd_o == SPD_CAP_G2)); // R4
    AST_TRAIN_AT_GEN1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(train_en_o) |-> (max_spd_o == SPD_CAP_G1)); // R2
    AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({busy_o, done_o, fail_o}) <= 1); // R9
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o); // R8
    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && !start_i) |=> fail_o); // R8

endmodule

// File: tb/sim_lnk_speed_seq.sv
`timescale 1ns/1ps
module sim_lnk_speed_seq;
    localparam int T = 4;
    localparam int P = 5;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic link_up = 1'b0, chg_busy = 1'b0;
    logic [3:0] gen_f = 4'd0;
    logic [3:0] max_spd, gen;
    logic train_en, req, busy, done, fail;

    lnk_speed_seq #(.TICK_CYC(T), .MAX_POLLS(P)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .link_up_i(link_up),
        .spd_chg_busy_i(chg_busy), .gen_field_i(gen_f), .max_spd_o(max_spd),
        .train_en_o(train_en), .spd_chg_req_o(req), .busy_o(busy),
        .done_o(done), .fail_o(fail), .gen_o(gen)
    );

    initial forever #2 clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // inputs as seen at the last rising edge
    bit s_rst, s_start, s_up, s_busy;
    int s_gen;
    initial forever begin
        @(posedge clk);
        s_rst = rst_n; s_start = start; s_up = link_up; s_busy = chg_busy; s_gen = gen_f;
    end

    // reference model: phase 0 idle,1 arm,2 enable,3 wait up,4 raise,5 wait chg,6 wait up again
    int m_ph, m_tk, m_pc, m_max, m_ten, m_req, m_busy, m_done, m_fail, m_gen;
    task automatic m_reset();
        m_ph = 0; m_tk = 0; m_pc = 0; m_max = 1; m_ten = 0; m_req = 0;
        m_busy = 0; m_done = 0; m_fail = 0; m_gen = 0;
    endtask
    task automatic m_step();
        bit ok;
        m_req = 0;
        if (s_start) begin
            m_ph = 1; m_ten = 0; m_busy = 1; m_done = 0; m_fail = 0; m_gen = 0;
            m_tk = 0; m_pc = 0;
        end else if (m_ph == 3 || m_ph == 5 || m_ph == 6) begin
            if (m_tk == T - 1) begin
                m_tk = 0;
                ok = (m_ph == 5) ? !s_busy : s_up;
                if (ok) begin
                    m_pc = 0;
                    if (m_ph == 3) begin m_max = 2; m_ph = 4; end
                    else if (m_ph == 5) m_ph = 6;
                    else begin m_done = 1; m_busy = 0; m_gen = s_gen; m_ph = 0; end
                end else if (m_pc == P - 1) begin
                    m_fail = 1; m_busy = 0; m_ph = 0; m_pc = 0;
                end else m_pc++;
            end else m_tk++;
        end else begin
            m_tk = 0; m_pc = 0;
            if (m_ph == 1) begin m_max = 1; m_ph = 2; end
            else if (m_ph == 2) begin m_ten = 1; m_ph = 3; end
            else if (m_ph == 4) begin m_req = 1; m_ph = 5; end
        end
    endtask

    // link partner knobs (-1 = never)
    int p_up1 = 6, p_chg = 5, p_up2 = 3, p_glitch = 0;
    int q_cnt = 0, q_ccnt = 0, q_cnt2 = 0;
    bit q_chg = 0, q_post = 0;

    initial begin
        m_reset();
        forever begin
            @(negedge clk);
            cyc++;
            if (!s_rst) m_reset(); else m_step();
            chk(max_spd == m_max, "R2 speed cap", max_spd, m_max);
            chk(train_en == m_ten, "R2 training enable", train_en, m_ten);
            chk(req == m_req, "R4 speed-change request", req, m_req);
            chk(busy == m_busy, "R9 busy", busy, m_busy);
            chk(done == m_done, "R7 done", done, m_done);
            chk(fail == m_fail, "R6 fail", fail, m_fail);
            chk(gen == m_gen, "R7 generation", gen, m_gen);
            // partner update
            if (!train_en) begin
                q_cnt = 0; q_chg = 0; q_post = 0; q_ccnt = 0; q_cnt2 = 0;
                link_up = 0; chg_busy = 0;
            end else if (req && !q_chg && !q_post) begin
                q_chg = 1; q_ccnt = 0; chg_busy = 1; link_up = 0;
            end else if (q_chg) begin
                q_ccnt++;
                if (p_chg >= 0 && q_ccnt >= p_chg) begin
                    chg_busy = 0; q_chg = 0; q_post = 1; q_cnt2 = 0;
                end
            end else if (q_post) begin
                q_cnt2++;
                link_up = (p_up2 >= 0 && q_cnt2 >= p_up2);
            end else begin
                q_cnt++;
                link_up = p_glitch != 0 ? (q_cnt % 4 == 1) : (p_up1 >= 0 && q_cnt >= p_up1);
            end
            if (cyc > 100000) begin
                chk(0, "R9 watchdog", cyc, 100000);
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
                $finish;
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(train_en == 1'b0 && busy == 1'b1, "R2 start withdraws enable",
            {train_en, busy}, 2'b01);
        chk(done == 1'b0 && fail == 1'b0, "R8 start clears status", {done, fail}, 0);
    endtask

    task automatic wait_end();
        int k = 0;
        while (!(done || fail) && k < 300) begin @(negedge clk); k++; end
        chk(k < 300, "R9 sequence ends", k, 300);
    endtask

    task automatic run(input int u1, input int c, input int u2, input int g,
                       input int gl, input bit exp_done, input string tag);
        p_up1 = u1; p_chg = c; p_up2 = u2; p_glitch = gl; gen_f = 4'(g);
        pulse_start();
        wait_end();
        chk(done == exp_done && fail == !exp_done, tag, {done, fail}, {exp_done, !exp_done});
        if (exp_done) chk(gen == 4'(g), "R7 latched generation", gen, g);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(max_spd == 4'd1 && !train_en && !req, "R1 reset controls", {max_spd, train_en, req}, 6'b000100);
        chk(!busy && !done && !fail && gen == 0, "R1 reset status", {busy, done, fail, gen}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        run(6, 5, 3, 2, 0, 1'b1, "R7 normal bring-up succeeds");
        repeat (6) @(negedge clk);
        chk(done == 1'b1, "R8 done holds while idle", done, 1);
        run(-1, 5, 3, 2, 0, 1'b0, "R6 link never up fails");
        repeat (6) @(negedge clk);
        chk(fail == 1'b1, "R8 fail holds while idle", fail, 1);
        run(6, -1, 3, 2, 0, 1'b0, "R5 stuck speed change fails");
        run(6, 5, -1, 2, 0, 1'b0, "R6 second link-up never comes fails");
        run(0, 1, 0, 1, 0, 1'b1, "R4 first-poll success, first gen result");
        run(20, 5, 3, 2, 0, 1'b1, "R6 link up on last allowed poll");
        run(21, 5, 3, 2, 0, 1'b0, "R6 link up one cycle too late");
        run(0, 5, 3, 2, 1, 1'b0, "R3 link-up only between polls is ignored");
        // restart in the middle of the speed-change wait
        p_up1 = 6; p_chg = -1; p_up2 = 2; p_glitch = 0; gen_f = 4'd2;
        pulse_start();
        repeat (16) @(negedge clk);
        chk(busy == 1'b1 && max_spd == 4'd2, "R8 mid-sequence before restart", {busy, max_spd}, 5'b10010);
        p_chg = 3;
        pulse_start();
        wait_end();
        chk(done == 1'b1, "R8 restart completes", done, 1);
        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule